// File: doc/BRIEF.md
# Per-ID Ordered Read Response Tracker

This block sits behind a read address channel and in front of several back-end targets that answer with different latencies. Each incoming read request carries an ID tag, a byte address and a burst length. The block decodes the target from the top address bits and forwards the request to that target with a routing tag. It also reserves a slot in a small ordering queue kept for that ID. Targets hand their data beats back, carrying the tag, whenever they are ready. The block stores the beats in the reserved slot and returns finished bursts on one valid/ready read data channel.

A queue exists per ID, so only requests with the same ID are held in issue order. A burst for one ID that completes early on a fast target can leave ahead of an older burst for another ID that is still waiting on a slow target. When several IDs have a complete burst at the head of their queue, a round-robin arbiter picks the next one. The chosen burst is sent beat after beat without interleaving. Requests to an address region with no target still take a slot and come back as error bursts.

Top module: `rrt_read_tracker`

## Requirements
- R1: Every returned beat carries on `r_id` the ID of a request that was accepted on the address channel with that ID and has not yet been fully returned.
- R2: Bursts that share an ID leave in the order their requests were accepted. Beat k of a burst carries the data the target supplied as its k-th beat.
- R3: A burst for one ID whose target answers first may leave before an older burst for a different ID that is still pending.
- R4: Up to 4 requests per ID are accepted before any data returns. `ar_ready` is low while the queue for the presented `ar_id` holds 4 entries, and stays high for an ID whose queue has room.
- R5: `ar_len` encodes beats minus one (0 to 15, giving 1 to 16 beats). `r_last` is high on the final beat of a burst and low on all the other beats.
- R6: Once the first beat of a burst is sent, every following beat up to `r_last` belongs to that same burst. No other ID appears in between.
- R7: While `r_valid` is high and `r_ready` is low, on the next cycle `r_valid` stays high and `r_id`, `r_data`, `r_resp` and `r_last` are unchanged.
- R8: When several IDs have a complete burst waiting, the next burst goes to the first waiting ID after the previously granted ID, counting upward and wrapping. After reset the search starts at ID 0.
- R9: A request whose `ar_addr[15:14]` selects no target (value 3 with three targets) is not forwarded. It still takes its slot in the ID order, and returns `r_resp` = 2'b10 with `r_data` = 0 on every beat. Mapped bursts return `r_resp` = 2'b00.
- R10: One cycle after a mapped request is accepted, exactly one bit `t` of `tq_valid` pulses, where t equals `ar_addr[15:14]`. `tq_addr` and `tq_len` are copied from the request. `tq_tag` holds the ID in bits [3:2] and the slot in bits [1:0].
- R11: After reset `r_valid` and `tq_valid` are low and `ar_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Request accepted when high with ar_valid |
| ar_id | input | 2 | Request ID tag |
| ar_addr | input | 16 | Request address; bits [15:14] pick the target |
| ar_len | input | 4 | Beats minus one |
| tq_valid | output | 3 | One-hot request pulse per target |
| tq_addr | output | 16 | Forwarded address |
| tq_len | output | 4 | Forwarded burst length |
| tq_tag | output | 4 | Routing tag {ID, slot} |
| cpl_valid | input | 3 | Per-target data beat valid |
| cpl_tag | input | 12 | Per-target routing tag, 4 bits per target |
| cpl_data | input | 96 | Per-target beat data, 32 bits per target |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Master accepts the beat |
| r_id | output | 2 | ID of the returned beat |
| r_data | output | 32 | Returned beat data |
| r_resp | output | 2 | Response status, 2'b00 okay, 2'b10 error |
| r_last | output | 1 | Final beat of the burst |

## Verification
A table of ten mixed requests spreads IDs over a fast, a slow and a medium target and the unmapped region, with lengths from 1 to 16 beats, under a ready pattern that stalls every third cycle. This separates correct per-ID order and beat data from mix-ups between targets. A directed pattern sends a slow request and then fast ones, with the same ID and with different IDs. It shows that only the different ID is allowed to overtake. Holding ready low while filling one ID's queue shows back-pressure that is specific to the ID. Queuing single-beat error bursts behind a stalled four-beat burst shows round-robin order, not fixed priority.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
   typedef enum logic [1:0] {
      RRT_OKAY   = 2'b00,
      RRT_SLVERR = 2'b10
   } rrt_resp_e;
endpackage

// File: rtl/rrt_tgt_decode.sv
module rrt_tgt_decode #(
   parameter int ADDR_W  = 16,
   parameter int TSEL_W  = 2,
   parameter int NUM_TGT = 3
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_TGT-1:0] tgt_hit,
   output logic               unmapped
);
   logic [TSEL_W-1:0] sel;
   assign sel = addr[ADDR_W-1 -: TSEL_W];

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_hit
      assign tgt_hit[t] = (sel == TSEL_W'(t));
   end

   assign unmapped = ~|tgt_hit;

   initial begin : p_chk
      AST_TGT_FITS: assert (NUM_TGT >= 1 && NUM_TGT <= (1 << TSEL_W) && TSEL_W < ADDR_W)
         else $error("target count does not fit select field"); // R10
   end
endmodule

// File: rtl/rrt_rr_arb.sv
module rrt_rr_arb #(
   parameter int N = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             take,
   output logic [IDX_W-1:0] grant_idx,
   output logic             any
);
   logic [IDX_W-1:0] last_q;

   always_comb begin
      int  idx;
      logic found;
      grant_idx = '0;
      found     = 1'b0;
      idx       = 0;
      for (int k = 1; k <= N; k++) begin
         idx = (int'(last_q) + k) % N;
         if (!found && req[idx]) begin
            grant_idx = IDX_W'(idx);
            found     = 1'b1;
         end
      end
   end

   assign any = |req;

   always_ff @(posedge clk) begin
      if (!rst_n)          last_q <= IDX_W'(N - 1);
      else if (take && any) last_q <= grant_idx;
   end

   AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[grant_idx]); // R8
   AST_GRANT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req) > 1) |-> (grant_idx != last_q)); // R8

   initial begin : p_chk
      AST_ARB_POW2: assert (N >= 2 && (N & (N - 1)) == 0)
         else $error("arbiter width must be a power of two"); // R8
   end
endmodule

// File: rtl/rrt_id_queue.sv
module rrt_id_queue #(
   parameter int ID_W      = 2,
   parameter int MY_ID     = 0,
   parameter int DEPTH     = 4,
   parameter int MAX_BEATS = 16,
   parameter int DATA_W    = 32,
   parameter int NUM_TGT   = 3,
   localparam int SLOT_W   = $clog2(DEPTH),
   localparam int LEN_W    = $clog2(MAX_BEATS),
   localparam int TAG_W    = ID_W + SLOT_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic [LEN_W-1:0]          push_len,
   input  logic                      push_err,
   output logic [SLOT_W-1:0]         alloc_slot,
   output logic                      full,
   input  logic [NUM_TGT-1:0]        cpl_valid,
   input  logic [NUM_TGT*TAG_W-1:0]  cpl_tag,
   input  logic [NUM_TGT*DATA_W-1:0] cpl_data,
   output logic                      head_done,
   output logic                      head_err,
   output logic [LEN_W-1:0]          head_len,
   input  logic [LEN_W-1:0]          rd_beat,
   input  logic                      pop,
   output logic [DATA_W-1:0]         rd_data
);
   logic [SLOT_W-1:0] head_q, tail_q;
   logic [SLOT_W:0]   count_q;
   logic [DEPTH-1:0]  valid_q, done_q, err_q;
   logic [LEN_W-1:0]  len_q   [DEPTH];
   logic [LEN_W-1:0]  wbeat_q [DEPTH];
   logic [DATA_W-1:0] mem_q   [DEPTH*MAX_BEATS];

   logic [NUM_TGT-1:0] hit;
   logic [SLOT_W-1:0]  hit_slot [NUM_TGT];

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_port
      assign hit[t]      = cpl_valid[t] &&
                           (cpl_tag[t*TAG_W+SLOT_W +: ID_W] == ID_W'(MY_ID));
      assign hit_slot[t] = cpl_tag[t*TAG_W +: SLOT_W];

      AST_CPL_OPEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
         hit[t] |-> (valid_q[hit_slot[t]] && !done_q[hit_slot[t]])); // R10
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         valid_q <= '0;
         done_q  <= '0;
         err_q   <= '0;
         for (int d = 0; d < DEPTH; d++) begin
            len_q[d]   <= '0;
            wbeat_q[d] <= '0;
         end
      end else begin
         if (push) begin
            len_q[tail_q]   <= push_len;
            err_q[tail_q]   <= push_err;
            done_q[tail_q]  <= push_err;
            valid_q[tail_q] <= 1'b1;
            wbeat_q[tail_q] <= '0;
            tail_q          <= tail_q + 1'b1;
         end
         for (int t = 0; t < NUM_TGT; t++) begin
            if (hit[t]) begin
               wbeat_q[hit_slot[t]] <= wbeat_q[hit_slot[t]] + 1'b1;
               if (wbeat_q[hit_slot[t]] == len_q[hit_slot[t]])
                  done_q[hit_slot[t]] <= 1'b1;
            end
         end
         if (pop) begin
            valid_q[head_q] <= 1'b0;
            done_q[head_q]  <= 1'b0;
            head_q          <= head_q + 1'b1;
         end
         count_q <= count_q + {{SLOT_W{1'b0}}, push} - {{SLOT_W{1'b0}}, pop};
      end
   end

   always_ff @(posedge clk) begin
      for (int t = 0; t < NUM_TGT; t++) begin
         if (hit[t])
            mem_q[{hit_slot[t], wbeat_q[hit_slot[t]]}] <= cpl_data[t*DATA_W +: DATA_W];
      end
   end

   assign full       = (count_q == (SLOT_W+1)'(DEPTH));
   assign alloc_slot = tail_q;
   assign head_done  = valid_q[head_q] & done_q[head_q];
   assign head_err   = err_q[head_q];
   assign head_len   = len_q[head_q];
   assign rd_data    = err_q[head_q] ? '0 : mem_q[{head_q, rd_beat}];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R4
   AST_POP_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_done); // R2

   initial begin : p_chk
      AST_QUEUE_POW2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("queue depth must be a power of two"); // R4
      AST_BEATS_POW2: assert (MAX_BEATS >= 2 && (MAX_BEATS & (MAX_BEATS - 1)) == 0)
         else $error("beat count must be a power of two"); // R5
   end
endmodule

// File: rtl/rrt_read_tracker.sv
module rrt_read_tracker
   import rrt_pkg::*;
#(
   parameter int ID_W      = 2,
   parameter int DEPTH     = 4,
   parameter int MAX_BEATS = 16,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 16,
   parameter int NUM_TGT   = 3,
   parameter int TSEL_W    = 2,
   localparam int NUM_ID   = 1 << ID_W,
   localparam int SLOT_W   = $clog2(DEPTH),
   localparam int LEN_W    = $clog2(MAX_BEATS),
   localparam int TAG_W    = ID_W + SLOT_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ar_valid,
   output logic                      ar_ready,
   input  logic [ID_W-1:0]           ar_id,
   input  logic [ADDR_W-1:0]         ar_addr,
   input  logic [LEN_W-1:0]          ar_len,
   output logic [NUM_TGT-1:0]        tq_valid,
   output logic [ADDR_W-1:0]         tq_addr,
   output logic [LEN_W-1:0]          tq_len,
   output logic [TAG_W-1:0]          tq_tag,
   input  logic [NUM_TGT-1:0]        cpl_valid,
   input  logic [NUM_TGT*TAG_W-1:0]  cpl_tag,
   input  logic [NUM_TGT*DATA_W-1:0] cpl_data,
   output logic                      r_valid,
   input  logic                      r_ready,
   output logic [ID_W-1:0]           r_id,
   output logic [DATA_W-1:0]         r_data,
   output logic [1:0]                r_resp,
   output logic                      r_last
);
   logic [NUM_TGT-1:0] tgt_hit;
   logic               unmapped;
   logic               accept;

   logic [NUM_ID-1:0]  full_v, push_v, pop_v, head_done_v, head_err_v;
   logic [SLOT_W-1:0]  slot_a     [NUM_ID];
   logic [LEN_W-1:0]   head_len_a [NUM_ID];
   logic [DATA_W-1:0]  rd_data_a  [NUM_ID];

   logic               busy_q;
   logic [ID_W-1:0]    cur_id_q;
   logic [LEN_W-1:0]   beat_q;
   logic [ID_W-1:0]    grant_idx;
   logic               grant_any;
   logic               at_last;

   rrt_tgt_decode #(.ADDR_W(ADDR_W), .TSEL_W(TSEL_W), .NUM_TGT(NUM_TGT)) u_dec (
      .addr     (ar_addr),
      .tgt_hit  (tgt_hit),
      .unmapped (unmapped)
   );

   assign ar_ready = !full_v[ar_id];
   assign accept   = ar_valid && ar_ready;
   assign at_last  = (beat_q == head_len_a[cur_id_q]);

   for (genvar i = 0; i < NUM_ID; i++) begin : g_id
      assign push_v[i] = accept && (ar_id == ID_W'(i));
      assign pop_v[i]  = busy_q && r_ready && (cur_id_q == ID_W'(i)) &&
                         (beat_q == head_len_a[i]);

      rrt_id_queue #(
         .ID_W(ID_W), .MY_ID(i), .DEPTH(DEPTH), .MAX_BEATS(MAX_BEATS),
         .DATA_W(DATA_W), .NUM_TGT(NUM_TGT)
      ) u_q (
         .clk        (clk),
         .rst_n      (rst_n),
         .push       (push_v[i]),
         .push_len   (ar_len),
         .push_err   (unmapped),
         .alloc_slot (slot_a[i]),
         .full       (full_v[i]),
         .cpl_valid  (cpl_valid),
         .cpl_tag    (cpl_tag),
         .cpl_data   (cpl_data),
         .head_done  (head_done_v[i]),
         .head_err   (head_err_v[i]),
         .head_len   (head_len_a[i]),
         .rd_beat    (beat_q),
         .pop        (pop_v[i]),
         .rd_data    (rd_data_a[i])
      );
   end

   rrt_rr_arb #(.N(NUM_ID)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (head_done_v),
      .take      (!busy_q),
      .grant_idx (grant_idx),
      .any       (grant_any)
   );

   // Forwarded request, registered one cycle after acceptance
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tq_valid <= '0;
         tq_addr  <= '0;
         tq_len   <= '0;
         tq_tag   <= '0;
      end else begin
         tq_valid <= (accept && !unmapped) ? tgt_hit : '0;
         if (accept) begin
            tq_addr <= ar_addr;
            tq_len  <= ar_len;
            tq_tag  <= {ar_id, slot_a[ar_id]};
         end
      end
   end

   // Burst streaming: lock one ID until its last beat is taken
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cur_id_q <= '0;
         beat_q   <= '0;
      end else if (!busy_q) begin
         if (grant_any) begin
            busy_q   <= 1'b1;
            cur_id_q <= grant_idx;
            beat_q   <= '0;
         end
      end else if (r_ready) begin
         if (at_last) busy_q <= 1'b0;
         else         beat_q <= beat_q + 1'b1;
      end
   end

   assign r_valid = busy_q;
   assign r_id    = cur_id_q;
   assign r_data  = rd_data_a[cur_id_q];
   assign r_last  = busy_q && at_last;
   assign r_resp  = head_err_v[cur_id_q] ? RRT_SLVERR : RRT_OKAY;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !r_ready) |=> (r_valid && $stable(r_id) && $stable(r_data) &&
                                 $stable(r_resp) && $stable(r_last))); // R7
   AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && r_ready && !r_last) |=> (r_valid && r_id == $past(r_id))); // R6
   AST_TQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tq_valid)); // R10
   AST_TQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (|tq_valid) |-> $past(ar_valid && ar_ready)); // R10
   AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && unmapped) |=> (tq_valid == '0)); // R9

   initial begin : p_chk
      AST_ID_RANGE: assert (ID_W >= 1 && ID_W <= 4)
         else $error("ID width out of range"); // R1
   end
endmodule

// File: tb/rrt_read_tracker_tb.sv
module rrt_read_tracker_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 3;
   localparam int LAT [NT] = '{2, 25, 6};
   localparam int NVEC = 10;
   // {id[21:20], addr[19:4], len[3:0]}
   localparam logic [21:0] VEC [NVEC] = '{
      {2'd0, 16'h4100, 4'd3},  {2'd0, 16'h0200, 4'd0},
      {2'd1, 16'h0300, 4'd15}, {2'd2, 16'h8400, 4'd2},
      {2'd1, 16'h4500, 4'd1},  {2'd3, 16'hC600, 4'd2},
      {2'd3, 16'h0700, 4'd4},  {2'd2, 16'h4800, 4'd0},
      {2'd0, 16'h8900, 4'd7},  {2'd1, 16'hCA00, 4'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ar_valid = 1'b0;
   logic ar_ready;
   logic [1:0] ar_id = '0;
   logic [15:0] ar_addr = '0;
   logic [3:0] ar_len = '0;
   logic [NT-1:0] tq_valid;
   logic [15:0] tq_addr;
   logic [3:0] tq_len;
   logic [3:0] tq_tag;
   logic [NT-1:0] cpl_valid = '0;
   logic [NT*4-1:0] cpl_tag = '0;
   logic [NT*32-1:0] cpl_data = '0;
   logic r_valid;
   logic r_ready = 1'b0;
   logic [1:0] r_id;
   logic [31:0] r_data;
   logic [1:0] r_resp;
   logic r_last;

   rrt_read_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
      .ar_addr(ar_addr), .ar_len(ar_len),
      .tq_valid(tq_valid), .tq_addr(tq_addr), .tq_len(tq_len), .tq_tag(tq_tag),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
      .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
      .r_resp(r_resp), .r_last(r_last)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int rmode = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Expected bursts per ID, in acceptance order
   logic [15:0] exp_addr [4][64];
   logic [3:0]  exp_len  [4][64];
   bit          exp_err  [4][64];
   int wp [4] = '{0, 0, 0, 0};
   int rp [4] = '{0, 0, 0, 0};
   logic [1:0] last_acc_id = '0;

   // Target models: fixed latency, in-order per target, one beat per cycle
   logic [15:0] tf_addr [NT][32];
   logic [3:0]  tf_len  [NT][32];
   logic [3:0]  tf_tag  [NT][32];
   int          tf_rdy  [NT][32];
   int tw [NT] = '{0, 0, 0};
   int tr [NT] = '{0, 0, 0};
   bit srv [NT] = '{0, 0, 0};
   int sbeat [NT] = '{0, 0, 0};

   always @(negedge clk) begin
      for (int t = 0; t < NT; t++) begin
         if (rst_n && tq_valid[t]) begin
            check(tq_addr[15:14] == 2'(t), "R10 target select", tq_addr[15:14], t);
            check(tq_tag[3:2] == last_acc_id, "R10 tag id", tq_tag[3:2], last_acc_id);
            tf_addr[t][tw[t]%32] = tq_addr;
            tf_len[t][tw[t]%32]  = tq_len;
            tf_tag[t][tw[t]%32]  = tq_tag;
            tf_rdy[t][tw[t]%32]  = cyc + LAT[t];
            tw[t]++;
         end
         cpl_valid[t] = 1'b0;
         if (!srv[t] && tr[t] != tw[t] && cyc >= tf_rdy[t][tr[t]%32]) begin
            srv[t] = 1'b1;
            sbeat[t] = 0;
         end
         if (srv[t]) begin
            cpl_valid[t] = 1'b1;
            cpl_tag[t*4 +: 4] = tf_tag[t][tr[t]%32];
            cpl_data[t*32 +: 32] = 32'(tf_addr[t][tr[t]%32]) + 32'(sbeat[t]);
            if (sbeat[t] == int'(tf_len[t][tr[t]%32])) begin
               srv[t] = 1'b0;
               tr[t]++;
            end else begin
               sbeat[t]++;
            end
         end
      end
   end

   // Read data monitor and scoreboard
   int bbeat = 0;
   logic [1:0] bid = '0;
   int ord_n = 0;
   logic [1:0] ord_id [64];
   logic [31:0] ord_dat [64];
   bit prev_v = 0, prev_rdy = 0;
   logic [1:0] prev_id = '0;
   logic [31:0] prev_data = '0;
   logic [1:0] prev_resp = '0;
   logic prev_last = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_v && !prev_rdy) begin
            check(r_valid && r_id == prev_id && r_data == prev_data &&
                  r_resp == prev_resp && r_last == prev_last,
                  "R7 hold under stall", {r_valid, r_id, r_data}, {1'b1, prev_id, prev_data});
         end
         r_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'b0 : (cyc % 3 != 0);
         if (r_valid && r_ready) begin
            if (bbeat == 0) begin
               ord_id[ord_n % 64] = r_id;
               ord_dat[ord_n % 64] = r_data;
               ord_n++;
               bid = r_id;
            end else begin
               check(r_id == bid, "R6 burst contiguous", r_id, bid);
            end
            if (wp[r_id] == rp[r_id]) begin
               check(1'b0, "R1 id with nothing pending", r_id, 0);
               bbeat = r_last ? 0 : bbeat + 1;
            end else begin
               automatic int k = rp[r_id] % 64;
               automatic logic [31:0] ed = exp_err[r_id][k] ? 32'd0 :
                                           32'(exp_addr[r_id][k]) + 32'(bbeat);
               check(r_data == ed, "R2 data in id order", r_data, ed);
               check(r_resp == (exp_err[r_id][k] ? 2'b10 : 2'b00), "R9 response",
                     r_resp, exp_err[r_id][k] ? 2 : 0);
               check(r_last == (bbeat == int'(exp_len[r_id][k])), "R5 last flag",
                     r_last, bbeat == int'(exp_len[r_id][k]));
               if (r_last) begin
                  rp[r_id]++;
                  bbeat = 0;
               end else begin
                  bbeat++;
               end
            end
         end
         prev_v = r_valid; prev_rdy = r_ready; prev_id = r_id;
         prev_data = r_data; prev_resp = r_resp; prev_last = r_last;
      end
   end

   task automatic send_req(input logic [1:0] id, input logic [15:0] addr, input logic [3:0] len);
      @(negedge clk);
      ar_valid = 1'b1; ar_id = id; ar_addr = addr; ar_len = len;
      #1;
      while (!ar_ready) begin
         @(negedge clk);
         #1;
      end
      exp_addr[id][wp[id]%64] = addr;
      exp_len[id][wp[id]%64]  = len;
      exp_err[id][wp[id]%64]  = (addr[15:14] == 2'd3);
      wp[id]++;
      last_acc_id = id;
      @(posedge clk);
      #1;
      ar_valid = 1'b0;
   endtask

   task automatic drain();
      bit idle = 0;
      while (!idle) begin
         @(negedge clk);
         #1;
         idle = !r_valid && (wp[0] == rp[0]) && (wp[1] == rp[1]) &&
                (wp[2] == rp[2]) && (wp[3] == rp[3]);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      int base;
      repeat (5) @(posedge clk);
      @(negedge clk);
      #1;
      // R11 reset state
      check(r_valid == 1'b0, "R11 r_valid after reset", r_valid, 0);
      check(tq_valid == '0, "R11 tq_valid after reset", tq_valid, 0);
      check(ar_ready == 1'b1, "R11 ar_ready after reset", ar_ready, 1);
      rst_n = 1'b1;

      // Table of mixed requests under a stalling ready pattern (R1 R2 R5 R9)
      rmode = 2;
      for (int v = 0; v < NVEC; v++) send_req(VEC[v][21:20], VEC[v][19:4], VEC[v][3:0]);
      drain();

      // R3 different ID overtakes, R2 same ID waits
      rmode = 0;
      base = ord_n;
      send_req(2'd0, 16'h4F00, 4'd0);
      send_req(2'd0, 16'h0F20, 4'd0);
      send_req(2'd1, 16'h0F10, 4'd0);
      drain();
      check(ord_id[base % 64] == 2'd1, "R3 fast other id first", ord_id[base % 64], 1);
      check(ord_dat[(base+1) % 64] == 32'h4F00, "R2 slow same id before fast",
            ord_dat[(base+1) % 64], 32'h4F00);
      check(ord_dat[(base+2) % 64] == 32'h0F20, "R2 fast same id after slow",
            ord_dat[(base+2) % 64], 32'h0F20);

      // R4 queue full for one ID, other ID still accepted
      rmode = 1;
      for (int k = 0; k < 4; k++) send_req(2'd2, 16'h8000 + 16'(k * 16), 4'd1);
      @(negedge clk);
      ar_valid = 1'b1; ar_id = 2'd2; ar_addr = 16'h8100; ar_len = 4'd0;
      #1;
      check(ar_ready == 1'b0, "R4 ready low when id full", ar_ready, 0);
      repeat (3) @(negedge clk);
      #1;
      check(ar_ready == 1'b0, "R4 ready stays low while full", ar_ready, 0);
      ar_id = 2'd3; ar_addr = 16'h0100;
      #1;
      check(ar_ready == 1'b1, "R4 other id accepted", ar_ready, 1);
      exp_addr[3][wp[3]%64] = 16'h0100;
      exp_len[3][wp[3]%64] = 4'd0;
      exp_err[3][wp[3]%64] = 1'b0;
      wp[3]++;
      last_acc_id = 2'd3;
      @(posedge clk);
      #1;
      ar_valid = 1'b0;
      repeat (30) @(negedge clk);
      rmode = 0;
      drain();

      // R8 round robin after a stalled burst of ID 1 (R9 error bursts)
      rmode = 1;
      base = ord_n;
      send_req(2'd1, 16'hC010, 4'd3);
      repeat (3) @(negedge clk);
      send_req(2'd0, 16'hC020, 4'd0);
      send_req(2'd2, 16'hC030, 4'd0);
      send_req(2'd3, 16'hC040, 4'd0);
      repeat (3) @(negedge clk);
      rmode = 0;
      drain();
      check(ord_id[base % 64] == 2'd1, "R8 first grant", ord_id[base % 64], 1);
      check(ord_id[(base+1) % 64] == 2'd2, "R8 next after id1", ord_id[(base+1) % 64], 2);
      check(ord_id[(base+2) % 64] == 2'd3, "R8 then id3", ord_id[(base+2) % 64], 3);
      check(ord_id[(base+3) % 64] == 2'd0, "R8 wrap to id0", ord_id[(base+3) % 64], 0);

      finish_run();
   end
endmodule